// File: doc/BRIEF.md
# Byte-wide SAR converter read sequencer

This block is the host-side master for a successive-approximation converter whose result leaves the converter over a parallel port, with only the upper eight data pins wired to the logic. A start request makes the block lower chip-select and wait out a guard time. It then drives a convert pulse and waits for the converter's busy line to drop. After that it fetches the result in two reads, with the byte-select line low for the first read and high for the second. The 16-bit word is delivered on `result_o` together with a valid strobe that lasts one cycle.

Every interval on the interface is a nanosecond parameter. It is rounded up to whole system-clock cycles. The block keeps reads, chip-select falls and byte-select changes out of a guard window on both sides of every convert edge. It leaves the required sampling time between a busy fall and the next convert edge. With the chaining input held high it starts each conversion as soon as the previous read completes, and chip-select stays low throughout. An abort command cuts off a running conversion by sending a second convert pulse. A watchdog raises a sticky error when busy stays high for too long.

Top module: `adc_byte_reader`

## Requirements
- R1: While reset is asserted and right after it, chip-select, convert and read are high (inactive), byte-select is 0, `result_o` is 0, and the valid strobe and the error flag are 0.
- R2: A start pulse in idle lowers chip-select. At least `QPRE` cycles later (5 at defaults) the convert line goes low for at least `CV_LO` cycles (2). Chip-select is low whenever convert is low.
- R3: The first read uses byte-select 0 and supplies result bits 15..8. The second read uses byte-select 1 and supplies bits 7..0 from the same eight pins. The assembled word appears on `result_o` with `result_vld_o` high for exactly one cycle.
- R4: Each read strobe stays low for at least `RD_LO` cycles (5) and needs chip-select low. Byte-select changes only while the read strobe is high.
- R5: No read fall, chip-select fall or byte-select change occurs in the `QPRE` cycles before a convert fall or the `QPOST` cycles (4) after it.
- R6: Reads start only after busy has fallen, as seen through a two-flop synchronizer. The next convert fall comes at least `SAMP` cycles (10) after that busy fall.
- R7: While `chain_i` is high, each finished read is followed by a new conversion and chip-select does not rise between them.
- R8: An abort pulse during a running conversion produces a second convert pulse, at least the abort setup time after the first. No result is delivered. The block waits for busy to drop and for the sampling window, then goes on.
- R9: An abort pulse while no conversion is running has no effect on the pins.
- R10: If busy has not fallen `TIMEOUT_CYC` cycles after the wait begins, the error flag is set and chip-select is raised. Only reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one conversion (taken in idle) |
| abort_i | input | 1 | Abort the running conversion |
| chain_i | input | 1 | Start the next conversion automatically |
| adc_busy_i | input | 1 | Converter busy, asynchronous |
| adc_data_i | input | 8 | Upper eight data pins of the converter |
| adc_cs_n_o | output | 1 | Chip-select, active low |
| adc_convst_n_o | output | 1 | Convert start, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Byte-select: 0 high byte, 1 low byte |
| result_o | output | 16 | Last assembled result |
| result_vld_o | output | 1 | One-cycle strobe for a new result |
| timeout_err_o | output | 1 | Sticky busy-timeout error |

## Verification
The hardest state to reach is an abort that lands inside a live conversion. It must come after the abort setup time but before busy drops, and the read path must stay silent afterwards. The bench's converter model keeps busy high for 35 cycles. The stimulus raises the abort a few cycles after it sees busy rise, so the command is held pending and is acted on only once the guard timer runs out. The model counts convert falls that arrive while busy is high, and the scoreboard confirms that no word comes out. The timeout is reached by freezing the model's busy line high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CSSET, ST_CVLO, ST_WAIT, ST_RD1, ST_RDH, ST_RD2,
    ST_GAP, ST_ABLO, ST_ABHI, ST_ABWT
  } rd_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_rstsync.sv
module adc_rd_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/adc_rd_sync.sv
module adc_rd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o
);
  logic m1_q, m2_q, m3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= 1'b0;
      m2_q <= 1'b0;
      m3_q <= 1'b0;
    end else begin
      m1_q <= d_i;
      m2_q <= m1_q;
      m3_q <= m2_q;
    end
  end

  assign lvl_o  = m2_q;
  assign fall_o = m3_q & ~m2_q;
endmodule

// File: rtl/adc_rd_tmr.sv
module adc_rd_tmr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)                cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_wdog.sv
module adc_rd_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q, cnt_d;

  assign expire = en && (cnt_q == W'(LIMIT - 1));

  always_comb begin
    if (!en)         cnt_d = '0;
    else if (expire) cnt_d = cnt_q;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_NS         = 10,
  parameter int CV_LO_NS       = 20,
  parameter int CV_HI_NS       = 20,
  parameter int QPRE_NS        = 50,
  parameter int QPOST_NS       = 40,
  parameter int RD_LO_NS       = 50,
  parameter int RD_HI_NS       = 20,
  parameter int SETTLE_NS      = 20,
  parameter int BYTE_GAP_NS    = 50,
  parameter int SAMP_NS        = 100,
  parameter int ABORT_SETUP_NS = 70,
  parameter int TIMEOUT_CYC    = 1000,
  parameter int DW             = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic            chain_i,
  input  logic            adc_busy_i,
  input  logic [DW-1:0]   adc_data_i,
  output logic            adc_cs_n_o,
  output logic            adc_convst_n_o,
  output logic            adc_rd_n_o,
  output logic            adc_byte_o,
  output logic [2*DW-1:0] result_o,
  output logic            result_vld_o,
  output logic            timeout_err_o
);

  // ---- cycle counts derived from nanosecond minimums ----
  localparam int CV_LO_CYC  = max2(1, ns2cyc(CV_LO_NS, CLK_NS));
  localparam int CV_HI_CYC  = max2(1, ns2cyc(CV_HI_NS, CLK_NS));
  localparam int QPRE_CYC   = max2(1, ns2cyc(QPRE_NS, CLK_NS));
  localparam int QPOST_CYC  = max2(1, ns2cyc(QPOST_NS, CLK_NS));
  localparam int SET_CYC    = ns2cyc(SETTLE_NS, CLK_NS);
  localparam int RD_LO_CYC  = max2(1, max2(ns2cyc(RD_LO_NS, CLK_NS), SET_CYC));
  localparam int RD_HI_CYC  = max2(1, max2(max2(ns2cyc(RD_HI_NS, CLK_NS), SET_CYC),
                                           ns2cyc(BYTE_GAP_NS, CLK_NS) - RD_LO_CYC));
  localparam int SAMP_CYC   = max2(1, ns2cyc(SAMP_NS, CLK_NS));
  localparam int ABORT_CYC  = ns2cyc(ABORT_SETUP_NS, CLK_NS);
  localparam int GAP_CYC    = max2(QPRE_CYC, CV_HI_CYC);
  localparam int WAIT_CYC   = max2(max2(QPOST_CYC, ABORT_CYC), CV_HI_CYC);
  localparam int TMR_MAX    = max2(max2(SAMP_CYC, WAIT_CYC),
                                   max2(max2(GAP_CYC, RD_LO_CYC), max2(RD_HI_CYC, CV_LO_CYC)));
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  // ---- infrastructure ----
  logic rst_n_s;
  logic busy_lvl, busy_fall;
  logic tmr_ld, tmr_done, samp_done, wd_en, wd_exp;
  logic [TMR_W-1:0] tmr_val;

  adc_rd_rstsync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_s));

  adc_rd_sync u_busy (
    .clk(clk), .rst_n(rst_n_s), .d_i(adc_busy_i),
    .lvl_o(busy_lvl), .fall_o(busy_fall)
  );

  adc_rd_tmr #(.W(TMR_W)) u_step (
    .clk(clk), .rst_n(rst_n_s), .ld(tmr_ld), .ld_val(tmr_val), .done(tmr_done)
  );

  adc_rd_tmr #(.W(TMR_W)) u_samp (
    .clk(clk), .rst_n(rst_n_s), .ld(busy_fall),
    .ld_val(TMR_W'(SAMP_CYC - 1)), .done(samp_done)
  );

  adc_rd_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n_s), .en(wd_en), .expire(wd_exp)
  );

  // ---- sequencer state ----
  rd_state_e state_q, state_d;
  logic fell_q, fell_d;
  logic abt_q, abt_d;
  logic cs_n_d, cv_n_d, rd_n_d, byte_d;
  logic [DW-1:0]   hi_q, hi_d;
  logic [2*DW-1:0] res_q, res_d;
  logic            vld_q, vld_d, err_q, err_d;
  logic            cs_n_q, cv_n_q, rd_n_q, byte_q;

  assign wd_en = (state_q == ST_WAIT) || (state_q == ST_ABWT);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CSSET;
      ST_CSSET: if (tmr_done) state_d = ST_CVLO;
      ST_CVLO:  if (tmr_done) state_d = ST_WAIT;
      ST_WAIT: begin
        if (wd_exp)                                      state_d = ST_IDLE;
        else if ((busy_fall || fell_q) && tmr_done)      state_d = ST_RD1;
        else if ((abt_q || abort_i) && tmr_done && busy_lvl) state_d = ST_ABLO;
      end
      ST_RD1:   if (tmr_done) state_d = ST_RDH;
      ST_RDH:   if (tmr_done) state_d = ST_RD2;
      ST_RD2:   if (tmr_done) state_d = ST_GAP;
      ST_GAP:   if (tmr_done && samp_done) state_d = chain_i ? ST_CVLO : ST_IDLE;
      ST_ABLO:  if (tmr_done) state_d = ST_ABHI;
      ST_ABHI:  if (tmr_done) state_d = ST_ABWT;
      ST_ABWT: begin
        if (wd_exp)         state_d = ST_IDLE;
        else if (!busy_lvl) state_d = ST_GAP;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  // step timer load, keyed on the state being entered
  assign tmr_ld = (state_d != state_q);
  always_comb begin
    unique case (state_d)
      ST_CSSET:        tmr_val = TMR_W'(QPRE_CYC - 1);
      ST_CVLO, ST_ABLO: tmr_val = TMR_W'(CV_LO_CYC - 1);
      ST_WAIT:         tmr_val = TMR_W'(WAIT_CYC - 1);
      ST_RD1, ST_RD2:  tmr_val = TMR_W'(RD_LO_CYC - 1);
      ST_RDH:          tmr_val = TMR_W'(RD_HI_CYC - 1);
      ST_GAP:          tmr_val = TMR_W'(GAP_CYC - 1);
      ST_ABHI:         tmr_val = TMR_W'(CV_HI_CYC - 1);
      default:         tmr_val = '0;
    endcase
  end

  // datapath and pin next values
  always_comb begin
    fell_d = (state_q == ST_WAIT) && (fell_q || busy_fall);
    abt_d  = (state_q == ST_WAIT) && (abt_q || abort_i);
    cs_n_d = (state_d == ST_IDLE);
    cv_n_d = !((state_d == ST_CVLO) || (state_d == ST_ABLO));
    rd_n_d = !((state_d == ST_RD1) || (state_d == ST_RD2));
    byte_d = (state_d == ST_RDH) || (state_d == ST_RD2);
    hi_d   = hi_q;
    if ((state_q == ST_RD1) && tmr_done) hi_d = adc_data_i;
    res_d  = res_q;
    vld_d  = (state_q == ST_RD2) && tmr_done;
    if (vld_d) res_d = {hi_q, adc_data_i};
    err_d  = err_q | wd_exp;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      fell_q  <= 1'b0;
      abt_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      cv_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      byte_q  <= 1'b0;
      hi_q    <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fell_q  <= fell_d;
      abt_q   <= abt_d;
      cs_n_q  <= cs_n_d;
      cv_n_q  <= cv_n_d;
      rd_n_q  <= rd_n_d;
      byte_q  <= byte_d;
      hi_q    <= hi_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
    end
  end

  assign adc_cs_n_o     = cs_n_q;
  assign adc_convst_n_o = cv_n_q;
  assign adc_rd_n_o     = rd_n_q;
  assign adc_byte_o     = byte_q;
  assign result_o       = res_q;
  assign result_vld_o   = vld_q;
  assign timeout_err_o  = err_q;

endmodule

// File: rtl/adc_byte_reader_chk.sv
module adc_byte_reader_chk #(
  parameter int CV_LO = 2,
  parameter int QPRE  = 5,
  parameter int QPOST = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic convst_n,
  input logic rd_n,
  input logic byte_sel,
  input logic busy,
  input logic vld,
  input logic err
);
  logic       p_cs, p_rd, p_byte, p_cv;
  logic [7:0] lo_cnt, act_age, cv_age;
  logic       act_now, cvf_now;

  assign act_now = (p_rd && !rd_n) || (p_cs && !cs_n) || (p_byte != byte_sel);
  assign cvf_now = p_cv && !convst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_cs <= 1'b1; p_rd <= 1'b1; p_byte <= 1'b0; p_cv <= 1'b1;
      lo_cnt <= '0; act_age <= 8'hFF; cv_age <= 8'hFF;
    end else begin
      p_cs <= cs_n; p_rd <= rd_n; p_byte <= byte_sel; p_cv <= convst_n;
      lo_cnt  <= convst_n ? 8'd0 : ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1);
      act_age <= act_now ? 8'd0 : ((act_age == 8'hFF) ? act_age : act_age + 8'd1);
      cv_age  <= cvf_now ? 8'd0 : ((cv_age == 8'hFF) ? cv_age : cv_age + 8'd1);
    end
  end

  a_r2_convst_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n |-> !cs_n);
  a_r2_convst_width: assert property (@(posedge clk) disable iff (!rst_n)
    (convst_n && !p_cv) |-> (lo_cnt >= 8'(CV_LO)));
  a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  a_r3_vld_after_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (!p_rd && p_byte));
  a_r4_byte_moves_rd_high: assert property (@(posedge clk) disable iff (!rst_n)
    (p_byte != byte_sel) |-> rd_n);
  a_r4_rd_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  a_r5_quiet_before: assert property (@(posedge clk) disable iff (!rst_n)
    cvf_now |-> (!act_now && act_age >= 8'(QPRE - 1)));
  a_r5_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    act_now |-> (!cvf_now && cv_age >= 8'(QPOST - 1)));
  a_r6_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !busy);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind adc_byte_reader adc_byte_reader_chk #(
  .CV_LO(CV_LO_CYC), .QPRE(QPRE_CYC), .QPOST(QPOST_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n_o), .convst_n(adc_convst_n_o),
  .rd_n(adc_rd_n_o), .byte_sel(adc_byte_o), .busy(adc_busy_i),
  .vld(result_vld_o), .err(timeout_err_o)
);

// File: tb/adc_byte_reader_bench.sv
module adc_byte_reader_bench;
  localparam int TO = 300;
  localparam int CONV = 35;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, abort = 1'b0, chain = 1'b0;
  logic busy, cs_n, cv_n, rd_n, bsel, vld, err;
  logic [7:0]  data;
  logic [15:0] result;

  adc_byte_reader #(.TIMEOUT_CYC(TO)) u_adc_byte_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort), .chain_i(chain),
    .adc_busy_i(busy), .adc_data_i(data), .adc_cs_n_o(cs_n), .adc_convst_n_o(cv_n),
    .adc_rd_n_o(rd_n), .adc_byte_o(bsel), .result_o(result), .result_vld_o(vld),
    .timeout_err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- converter model ----
  logic        m_busy = 1'b0, m_abort = 1'b0, m_stuck = 1'b0;
  logic [15:0] m_dreg = 16'h0, m_pend = 16'h0;
  int m_cnt = 0, cyc = 0;
  int last_act = -1000, last_cvf = -1000, last_bfall = -1000, rd_fall_t = 0;
  int n_starts = 0, n_aborts = 0, n_cs_rise = 0, n_vld = 0;
  logic p_cs = 1'b1, p_rd = 1'b1, p_byte = 1'b0, p_cv = 1'b1;
  logic [15:0] conv_q[$];
  logic [15:0] exp_q[$];

  assign busy = m_busy;
  assign data = (!cs_n && !rd_n) ? (bsel ? m_dreg[7:0] : m_dreg[15:8]) : 8'hA5;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ((p_rd && !rd_n) || (p_cs && !cs_n) || (p_byte != bsel)) begin
        chk(cyc - last_cvf >= 4, "R5", "activity too soon after convert", cyc - last_cvf, 4);
        last_act = cyc;
      end
      if (!p_cs && cs_n) n_cs_rise++;
      if (p_rd && !rd_n) begin
        rd_fall_t = cyc;
        chk(!m_busy, "R6", "read while busy", int'(m_busy), 0);
      end
      if (!p_rd && rd_n)
        chk(cyc - rd_fall_t >= 5, "R4", "read low width", cyc - rd_fall_t, 5);
      if (!p_cv && cv_n)
        chk(cyc - last_cvf >= 2, "R2", "convert low width", cyc - last_cvf, 2);
      if (p_cv && !cv_n) begin
        chk(!cs_n, "R2", "cs low at convert", int'(cs_n), 0);
        chk(cyc - last_act >= 5, "R5", "activity too close before convert", cyc - last_act, 5);
        if (m_busy) begin
          chk(cyc - last_cvf >= 7, "R8", "abort setup", cyc - last_cvf, 7);
          n_aborts++;
          m_abort = 1'b1;
          m_cnt = 3;
        end else begin
          chk(cyc - last_bfall >= 10, "R6", "sampling window", cyc - last_bfall, 10);
          n_starts++;
          m_pend = (conv_q.size() != 0) ? conv_q.pop_front() : 16'hDEAD;
          m_busy = 1'b1;
          m_abort = 1'b0;
          m_cnt = CONV;
        end
        last_cvf = cyc;
      end else if (m_busy && !m_stuck) begin
        if (m_cnt > 0) m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          last_bfall = cyc;
          if (!m_abort) m_dreg = m_pend;
        end
      end
    end
    p_cs = cs_n; p_rd = rd_n; p_byte = bsel; p_cv = cv_n;
  end

  // ---- scoreboard monitor ----
  always @(negedge clk) begin
    if (rst_n && vld) begin
      n_vld++;
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected result", int'(result), 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R3", "result word", int'(result), int'(e));
      end
    end
  end

  // ---- driver ----
  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic convert(input logic [15:0] w);
    conv_q.push_back(w);
    exp_q.push_back(w);
    pulse_start();
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] pats[8];
    int b_vld, b_st, b_ab, b_cr;
    pats = '{16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h1234, 16'hA55A, 16'h00FF, 16'hFF00};

    repeat (4) @(negedge clk);
    chk(cs_n && cv_n && rd_n && !bsel, "R1", "pins in reset", {cs_n, cv_n, rd_n, bsel}, 4'b1110);
    chk(result == 16'h0 && !vld && !err, "R1", "outputs in reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n && cv_n && rd_n && !bsel, "R1", "pins after reset", {cs_n, cv_n, rd_n, bsel}, 4'b1110);

    // R2 / R3: single conversions over distinct bit patterns
    foreach (pats[i]) begin
      convert(pats[i]);
      drain();
    end
    chk(n_vld == 8, "R3", "result count", n_vld, 8);
    chk(cs_n, "R2", "idle after single read", int'(cs_n), 1);

    // R9: abort with nothing running
    b_st = n_starts; b_ab = n_aborts;
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (30) @(negedge clk);
    chk(n_starts == b_st && n_aborts == b_ab, "R9", "convert pulses after idle abort",
        n_starts + n_aborts, b_st + b_ab);
    chk(cs_n && cv_n, "R9", "pins idle after abort", {cs_n, cv_n}, 2'b11);

    // R7: chained conversions
    b_vld = n_vld; b_st = n_starts; b_cr = n_cs_rise;
    chain = 1'b1;
    for (int k = 0; k < 4; k++) begin
      conv_q.push_back(16'h1111 * (k + 3));
      exp_q.push_back(16'h1111 * (k + 3));
    end
    pulse_start();
    while (n_vld < b_vld + 4) @(negedge clk);
    chain = 1'b0;
    drain();
    chk(n_starts - b_st == 4, "R7", "chained starts", n_starts - b_st, 4);
    chk(n_cs_rise - b_cr == 1, "R7", "cs rises across chain", n_cs_rise - b_cr, 1);

    // R8: abort during a conversion
    b_vld = n_vld; b_ab = n_aborts;
    conv_q.push_back(16'hBEEF);
    pulse_start();
    while (!m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
    abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (80) @(negedge clk);
    chk(n_aborts - b_ab == 1, "R8", "abort pulses", n_aborts - b_ab, 1);
    chk(n_vld == b_vld, "R8", "no result after abort", n_vld, b_vld);
    chk(cs_n && !m_busy, "R8", "back to idle", {cs_n, m_busy}, 2'b10);
    convert(16'h5AA5);
    drain();
    chk(n_vld == b_vld + 1, "R8", "conversion after abort", n_vld, b_vld + 1);

    // R10: busy stuck high
    m_stuck = 1'b1;
    conv_q.push_back(16'h0F0F);
    pulse_start();
    repeat (TO / 2) @(negedge clk);
    chk(!err, "R10", "error before limit", int'(err), 0);
    repeat (TO + 30) @(negedge clk);
    chk(err, "R10", "error after limit", int'(err), 1);
    chk(cs_n, "R10", "cs released on timeout", int'(cs_n), 1);
    m_stuck = 1'b0;
    repeat (60) @(negedge clk);
    convert(16'hC3C3);
    drain();
    chk(err, "R10", "error stays set", int'(err), 1);

    // R1: reset clears the sticky flag and the result
    rst_n = 1'b0;
    @(negedge clk);
    chk(!err && result == 16'h0, "R1", "reset clears error and result", {err, result}, 0);
    finish_run();
  end
endmodule